// File: doc/BRIEF.md
# Current-Chopping Full-Bridge Controller

This block is the digital core that runs one full bridge feeding an inductive winding. Two command inputs choose the polarity of each half of the bridge. A free-running cycle timer opens a new drive phase at a fixed rate. During that phase an external current-trip comparator, brought in as a digital level, ends the drive. The trip is ignored for a blanking window at the start of every phase, and that window also sets the shortest possible on time.

After a trip, the winding recirculates until the period ends. It uses one of three decay policies: slow, where both low switches are on; fast, where the legs are swapped and switched off once the current reaches zero; and mixed, which runs fast and then changes to slow at three quarters of the period. Each leg has its own gate stage, which keeps a dead time between releasing one switch and closing the other. A two-bit current level code is passed on to an external reference scaler. The code that marks zero current shuts the bridge off at once.

Top module: `chop_bridge_ctrl`

## Requirements
- R1: At the start of each period the legs follow the latched command: bit 0 of `dir_in` drives leg A and bit 1 drives leg B. A bit set to 1 turns on the high switch of that leg and a bit set to 0 turns on the low switch. Gate bit 0 is leg A and gate bit 1 is leg B.
- R2: Periods are `PERIOD_CYC` clocks long. Every period starts with a drive phase, whatever decay state the previous period ended in.
- R3: `trip_in` passes through a two-flop synchronizer. It is not acted on while the cycle count is below `BLANK_CYC`. With the trip held high from the period start, the drive gates stay on through cycle `BLANK_CYC+1` and change in cycle `BLANK_CYC+2`.
- R4: `decay_sel` = 00 (slow): after a trip, both legs go to their low switch until the period ends.
- R5: `decay_sel` = 10 (fast): after a trip, each leg takes the command bit of the other leg, which reverses the winding polarity. A high `zero_cur` in this state turns every switch off until the period ends.
- R6: `decay_sel` = 01 or 11 (mixed): the bridge behaves as in fast decay until the cycle count reaches `PERIOD_CYC*3/4`. From then on, and for any trip that comes later in the period, it uses slow decay.
- R7: The high and low switch of a leg are never on together. When a leg changes switch, both of its switches stay off for at least `DEAD_CYC` clocks (with the defaults, 3 clocks).
- R8: A `level_code` of 11 turns every switch off one clock later, in the middle of a period as well. The bridge enables again only at the next period start, and only if the code is no longer 11.
- R9: A change to `dir_in`, or to a `level_code` other than 11, made in the middle of a period takes effect at the next period start. `level_out` shows the code that is in effect.
- R10: While reset is active, all four gate outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with the clock inside the block |
| dir_in | input | 2 | Polarity command, bit 0 for leg A and bit 1 for leg B |
| level_code | input | 2 | Current level: 00 full, 01 about 71%, 10 about 38%, 11 bridge off |
| decay_sel | input | 2 | Decay policy: 00 slow, 10 fast, 01 or 11 mixed |
| trip_in | input | 1 | Asynchronous current-trip comparator level |
| zero_cur | input | 1 | Winding current has fallen to zero |
| gate_hi | output | 2 | High-switch enables, bit 0 for leg A |
| gate_lo | output | 2 | Low-switch enables, bit 0 for leg A |
| level_out | output | 2 | Current level code in effect, sent to the reference scaler |

## Verification
If the period counter or the decay state were wrong, the gate pattern would shift or stick. That error shows up at the latest at the next period start, when every leg has to come back to its drive switch within four clocks. An error in the dead-time counter of a leg shows up as an early or late gate edge in the first clocks after any switch change. An error in the latched command or code shows up as `level_out` or a gate changing in the middle of a period rather than at its start, one clock after the input moves. The expected timing is counted from the first drive edge after reset, period by period.

// File: rtl/chop_pkg.sv
package chop_pkg;
  typedef enum logic [1:0] {
    PH_DRIVE = 2'd0,
    PH_SLOW  = 2'd1,
    PH_FAST  = 2'd2,
    PH_OFF   = 2'd3
  } phase_t;

  typedef enum logic [1:0] {
    LV_OFF  = 2'd0,
    LV_HIGH = 2'd1,
    LV_LOW  = 2'd2
  } leg_lvl_t;

  localparam logic [1:0] DCY_SLOW = 2'b00;
  localparam logic [1:0] DCY_FAST = 2'b10;
  localparam logic [1:0] CODE_OFF = 2'b11;
endpackage

// File: rtl/chop_sync2.sv
module chop_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_async;
      sync_q <= meta_q;
    end
  end

  assign d_sync = sync_q;
endmodule

// File: rtl/chop_cycle_timer.sv
module chop_cycle_timer #(
  parameter int PERIOD_CYC = 200,
  parameter int BLANK_CYC  = 38
) (
  input  logic clk,
  input  logic rst_n,
  output logic at_start,
  output logic at_last,
  output logic blank_open,
  output logic mix_reached
);
  localparam int CW     = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
  localparam int MIX_AT = (PERIOD_CYC * 3) / 4;
  localparam logic [CW-1:0] LAST_V  = CW'(PERIOD_CYC - 1);
  localparam logic [CW-1:0] BLANK_V = CW'(BLANK_CYC);
  localparam logic [CW-1:0] MIX_V   = CW'(MIX_AT);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    if (cnt_q == LAST_V) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign at_start    = (cnt_q == '0);
  assign at_last     = (cnt_q == LAST_V);
  assign blank_open  = (cnt_q >= BLANK_V);
  assign mix_reached = (cnt_q >= MIX_V);

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_V);

  // R2
  period_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    at_last |=> at_start);
endmodule

// File: rtl/chop_phase_fsm.sv
module chop_phase_fsm
  import chop_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       at_last,
  input  logic       blank_open,
  input  logic       mix_reached,
  input  logic       trip_s,
  input  logic       zero_cur,
  input  logic [1:0] decay_sel,
  output phase_t     phase
);
  phase_t phase_q;
  phase_t phase_d;
  logic   is_mixed;

  assign is_mixed = (decay_sel != DCY_SLOW) && (decay_sel != DCY_FAST);

  always_comb begin
    phase_d = phase_q;
    if (at_last) begin
      phase_d = PH_DRIVE;
    end else begin
      case (phase_q)
        PH_DRIVE: begin
          if (blank_open && trip_s) begin
            if (decay_sel == DCY_SLOW)      phase_d = PH_SLOW;
            else if (decay_sel == DCY_FAST) phase_d = PH_FAST;
            else if (mix_reached)           phase_d = PH_SLOW;
            else                            phase_d = PH_FAST;
          end
        end
        PH_FAST: begin
          if (is_mixed && mix_reached) phase_d = PH_SLOW;
          else if (zero_cur)           phase_d = PH_OFF;
        end
        PH_OFF: begin
          if (is_mixed && mix_reached) phase_d = PH_SLOW;
        end
        default: phase_d = phase_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_DRIVE;
    else        phase_q <= phase_d;
  end

  assign phase = phase_q;

  // R3
  blank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DRIVE && !blank_open) |=> (phase_q == PH_DRIVE));

  // R4
  decay_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_DRIVE && !at_last) |=> (phase_q != PH_DRIVE));

  // R2
  drive_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    at_last |=> (phase_q == PH_DRIVE));
endmodule

// File: rtl/chop_leg_gate.sv
module chop_leg_gate
  import chop_pkg::*;
#(
  parameter int DEAD_CYC = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  leg_lvl_t target,
  output logic     gate_hi,
  output logic     gate_lo
);
  localparam int DW = $clog2(DEAD_CYC + 1);
  localparam logic [DW-1:0] DEAD_V = DW'(DEAD_CYC);

  leg_lvl_t      cur_q;
  leg_lvl_t      cur_d;
  logic [DW-1:0] dc_q;
  logic [DW-1:0] dc_d;

  always_comb begin
    cur_d = cur_q;
    dc_d  = dc_q;
    if (cur_q != LV_OFF) begin
      if (target != cur_q) begin
        cur_d = LV_OFF;
        dc_d  = DEAD_V;
      end
    end else if (dc_q != '0) begin
      dc_d = dc_q - 1'b1;
    end else if (target != LV_OFF) begin
      cur_d = target;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= LV_OFF;
      dc_q  <= '0;
    end else begin
      cur_q <= cur_d;
      dc_q  <= dc_d;
    end
  end

  assign gate_hi = (cur_q == LV_HIGH);
  assign gate_lo = (cur_q == LV_LOW);

  // R7
  leg_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo));

  // R7
  dead_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_lo) |-> (!$past(gate_hi, 1) && !$past(gate_hi, 2)));

  // R7
  dead_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_hi) |-> (!$past(gate_lo, 1) && !$past(gate_lo, 2)));
endmodule

// File: rtl/chop_bridge_ctrl.sv
module chop_bridge_ctrl
  import chop_pkg::*;
#(
  parameter int PERIOD_CYC = 200,
  parameter int BLANK_CYC  = 38,
  parameter int DEAD_CYC   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] dir_in,
  input  logic [1:0] level_code,
  input  logic [1:0] decay_sel,
  input  logic       trip_in,
  input  logic       zero_cur,
  output logic [1:0] gate_hi,
  output logic [1:0] gate_lo,
  output logic [1:0] level_out
);
  localparam int NLEG = 2;

  logic       rst_meta_q;
  logic       rst_ni;
  logic       at_start;
  logic       at_last;
  logic       blank_open;
  logic       mix_reached;
  logic       trip_s;
  phase_t     phase;
  logic [1:0] dir_q;
  logic [1:0] dir_d;
  logic [1:0] code_q;
  logic [1:0] code_d;
  logic [1:0] dir_eff;
  logic [1:0] code_eff;
  logic       bridge_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_ni     <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_ni     <= rst_meta_q;
    end
  end

  chop_cycle_timer #(
    .PERIOD_CYC (PERIOD_CYC),
    .BLANK_CYC  (BLANK_CYC)
  ) u_timer (
    .clk         (clk),
    .rst_n       (rst_ni),
    .at_start    (at_start),
    .at_last     (at_last),
    .blank_open  (blank_open),
    .mix_reached (mix_reached)
  );

  chop_sync2 #(.W(1)) u_trip_sync (
    .clk     (clk),
    .rst_n   (rst_ni),
    .d_async (trip_in),
    .d_sync  (trip_s)
  );

  chop_phase_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_ni),
    .at_last     (at_last),
    .blank_open  (blank_open),
    .mix_reached (mix_reached),
    .trip_s      (trip_s),
    .zero_cur    (zero_cur),
    .decay_sel   (decay_sel),
    .phase       (phase)
  );

  // command held for the whole period; zero-current code overrides at once
  always_comb begin
    dir_eff  = at_start ? dir_in : dir_q;
    if (level_code == CODE_OFF) code_eff = CODE_OFF;
    else                        code_eff = at_start ? level_code : code_q;
    dir_d  = at_start ? dir_in : dir_q;
    code_d = (at_start || level_code == CODE_OFF) ? level_code : code_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      code_q <= '0;
    end else begin
      dir_q  <= dir_d;
      code_q <= code_d;
    end
  end

  assign bridge_off = (code_eff == CODE_OFF);
  assign level_out  = code_eff;

  for (genvar g = 0; g < NLEG; g++) begin : g_leg
    leg_lvl_t tgt;

    always_comb begin
      if (bridge_off) begin
        tgt = LV_OFF;
      end else begin
        case (phase)
          PH_DRIVE: tgt = dir_eff[g] ? LV_HIGH : LV_LOW;
          PH_FAST:  tgt = dir_eff[NLEG-1-g] ? LV_HIGH : LV_LOW;
          PH_SLOW:  tgt = LV_LOW;
          default:  tgt = LV_OFF;
        endcase
      end
    end

    chop_leg_gate #(.DEAD_CYC(DEAD_CYC)) u_leg (
      .clk     (clk),
      .rst_n   (rst_ni),
      .target  (tgt),
      .gate_hi (gate_hi[g]),
      .gate_lo (gate_lo[g])
    );
  end

  // R8
  code_off_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (level_code == CODE_OFF) |=> (gate_hi == 2'b00 && gate_lo == 2'b00));

  // R9
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!at_start && level_code != CODE_OFF && !$past(level_code == CODE_OFF)
      && $past(!at_start)) |-> (level_out == $past(level_out) || at_start));
endmodule

// File: tb/chop_bridge_ctrl_test.sv
module chop_bridge_ctrl_test;
  localparam int PER   = 40;
  localparam int BLANK = 8;
  localparam int DEAD  = 2;

  logic       clk;
  logic       rst_n;
  logic [1:0] dir_in;
  logic [1:0] level_code;
  logic [1:0] decay_sel;
  logic       trip_in;
  logic       zero_cur;
  logic [1:0] gate_hi;
  logic [1:0] gate_lo;
  logic [1:0] level_out;

  int checks;
  int errors;
  int cyc;
  int base;
  bit done;

  chop_bridge_ctrl #(
    .PERIOD_CYC (PER),
    .BLANK_CYC  (BLANK),
    .DEAD_CYC   (DEAD)
  ) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .dir_in     (dir_in),
    .level_code (level_code),
    .decay_sel  (decay_sel),
    .trip_in    (trip_in),
    .zero_cur   (zero_cur),
    .gate_hi    (gate_hi),
    .gate_lo    (gate_lo),
    .level_out  (level_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int pos();
    return (cyc - base) % PER;
  endfunction

  task automatic goto(input int v);
    @(negedge clk);
    while (pos() != v) @(negedge clk);
  endtask

  task automatic chk_gates(input string req, input logic [1:0] hi_e, input logic [1:0] lo_e);
    checks++;
    if (gate_hi !== hi_e || gate_lo !== lo_e) begin
      errors++;
      $display("FAIL %s at pos %0d: hi=%b lo=%b expected hi=%b lo=%b",
               req, pos(), gate_hi, gate_lo, hi_e, lo_e);
    end
  endtask

  task automatic chk_level(input string req, input logic [1:0] exp_v);
    checks++;
    if (level_out !== exp_v) begin
      errors++;
      $display("FAIL %s at pos %0d: level_out=%b expected %b", req, pos(), level_out, exp_v);
    end
  endtask

  task automatic t_reset_align();
    rst_n = 1'b0; dir_in = 2'b01; level_code = 2'b00; decay_sel = 2'b00;
    trip_in = 1'b0; zero_cur = 1'b0; base = 0;
    repeat (3) @(negedge clk);
    chk_gates("R10 reset", 2'b00, 2'b00);
    rst_n = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (gate_hi[0] === 1'b1) break;
    end
    base = cyc - 1;
    chk_gates("R1 dir 01", 2'b01, 2'b10);
  endtask

  task automatic t_slow();
    goto(12); trip_in = 1'b1;
    goto(16); chk_gates("R4 slow leg A released", 2'b00, 2'b10);
    goto(19); chk_gates("R4 slow both low", 2'b00, 2'b11);
    trip_in = 1'b0;
    goto(3);  chk_gates("R7 dead time at restart", 2'b00, 2'b10);
    goto(4);  chk_gates("R2 drive restart", 2'b01, 2'b10);
  endtask

  task automatic t_blank();
    goto(0);  trip_in = 1'b1;
    goto(9);  chk_gates("R3 blanking holds drive", 2'b01, 2'b10);
    goto(10); chk_gates("R3 trip after blanking", 2'b00, 2'b10);
    goto(20); trip_in = 1'b0;
    goto(4);  chk_gates("R2 drive after blanked period", 2'b01, 2'b10);
  endtask

  task automatic t_fast();
    goto(5);  decay_sel = 2'b10;
    goto(12); trip_in = 1'b1;
    goto(16); chk_gates("R5 fast both released", 2'b00, 2'b00);
    goto(19); chk_gates("R5 fast reversed", 2'b10, 2'b01);
    trip_in = 1'b0;
    goto(22); zero_cur = 1'b1;
    goto(24); chk_gates("R5 zero current off", 2'b00, 2'b00);
    zero_cur = 1'b0;
    goto(39); chk_gates("R5 off until period end", 2'b00, 2'b00);
    goto(1);  chk_gates("R2 drive after off", 2'b01, 2'b10);
  endtask

  task automatic t_mixed();
    goto(5);  decay_sel = 2'b01;
    goto(12); trip_in = 1'b1;
    goto(19); chk_gates("R6 mixed starts fast", 2'b10, 2'b01);
    trip_in = 1'b0;
    goto(31); chk_gates("R6 fast before switch", 2'b10, 2'b01);
    goto(32); chk_gates("R6 leg B released", 2'b00, 2'b01);
    goto(35); chk_gates("R6 slow after switch", 2'b00, 2'b11);
    goto(4);  chk_gates("R2 drive after mixed", 2'b01, 2'b10);
    goto(30); trip_in = 1'b1;
    goto(34); chk_gates("R6 late trip goes slow", 2'b00, 2'b10);
    goto(37); chk_gates("R6 late trip both low", 2'b00, 2'b11);
    trip_in = 1'b0;
    goto(4);  chk_gates("R2 drive after late trip", 2'b01, 2'b10);
  endtask

  task automatic t_dir();
    decay_sel = 2'b00;
    goto(10); dir_in = 2'b10;
    goto(39); chk_gates("R9 direction deferred", 2'b01, 2'b10);
    goto(1);  chk_gates("R7 both legs released", 2'b00, 2'b00);
    goto(4);  chk_gates("R1 dir 10", 2'b10, 2'b01);
    goto(10); dir_in = 2'b11;
    goto(1);  chk_gates("R7 leg A released only", 2'b10, 2'b00);
    goto(4);  chk_gates("R1 dir 11", 2'b11, 2'b00);
    goto(10); dir_in = 2'b00;
    goto(4);  chk_gates("R1 dir 00", 2'b00, 2'b11);
  endtask

  task automatic t_level();
    goto(10); level_code = 2'b01;
    goto(20); chk_level("R9 level deferred", 2'b00);
    goto(0);  chk_level("R9 level at boundary 01", 2'b01);
    goto(10); level_code = 2'b10;
    goto(0);  chk_level("R9 level at boundary 10", 2'b10);
    goto(10); level_code = 2'b00;
    goto(0);  chk_level("R9 level back to 00", 2'b00);
  endtask

  task automatic t_disable();
    goto(10); level_code = 2'b11;
    goto(11); chk_gates("R8 immediate off", 2'b00, 2'b00);
    chk_level("R8 level shows off", 2'b11);
    goto(15); level_code = 2'b00;
    goto(20); chk_gates("R8 stays off in period", 2'b00, 2'b00);
    chk_level("R8 off code held", 2'b11);
    goto(0);  chk_level("R8 re-enable at boundary", 2'b00);
    goto(1);  chk_gates("R8 drive resumes", 2'b00, 2'b11);
  endtask

  initial begin
    checks = 0; errors = 0; done = 0;
    t_reset_align();
    t_slow();
    t_blank();
    t_fast();
    t_mixed();
    t_dir();
    t_level();
    t_disable();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired at pos %0d", pos());
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule